// File: doc/BRIEF.md
# Receive Byte Queue with Channel Routing

This block holds up to sixteen received bytes for a serial controller and decides, from a two-bit channel mode, where each byte goes. Bytes come from a deserializer. Writes to the data register come from the bus. Depending on the mode, a byte is stored in the queue, forwarded to the transmitter, or both. The bus drains the queue by reading the data register.

The block reports empty, full and trigger-level flags, plus a one-cycle overrun pulse, to the interrupt logic. A receiver enable bit and a receiver disable bit, both held inside the block, gate every store and every read. A self-clearing reset command empties the queue at once. A writable trigger threshold sets the occupancy at which the trigger flag rises.

Top module: `rx_byte_queue`

## Requirements
- R1: The queue holds up to 16 bytes. `st_empty` is high when it holds none and `st_full` is high when it holds 16; after reset it is empty.
- R2: In channel mode 0 (normal), a deserializer byte is stored, and a bus write to the data register is forwarded to the transmitter without being stored.
- R3: In channel mode 1 (echo), a deserializer byte is both stored and forwarded to the transmitter.
- R4: In channel mode 2 (local loopback), a bus write to the data register is stored and not forwarded, and deserializer bytes are ignored.
- R5: In channel mode 3 (remote loopback), a deserializer byte is forwarded to the transmitter and not stored.
- R6: A byte offered while the queue holds 16 entries is discarded, the stored contents stay unchanged, and `ovr_pulse` is high for exactly one cycle.
- R7: `st_trig` is high exactly while the occupancy is at least the threshold. The threshold resets to 32 (so the flag stays low at reset), and `trig_wr` loads it from `trig_wdata`.
- R8: A read of an empty queue returns zero and leaves `st_empty` high.
- R9: The receiver is active only while its enable bit is 1 and its disable bit is 0. Reset leaves enable 0 and disable 1. A `ctl_wr` loads both bits from `ctl_rx_en` and `ctl_rx_dis`. While the receiver is inactive, bytes are not stored and reads return zero without removing an entry.
- R10: A `ctl_wr` with `ctl_rx_rst` set empties the queue: the next cycle shows `st_empty` high, `st_full` low, and the earlier bytes are gone.
- R11: Bytes leave in arrival order. An accepted store and an accepted read in the same cycle leave the occupancy unchanged.
- R12: `rd_data` is updated one cycle after `bus_rd` and holds until the next read. `tx_valid` and `tx_byte` appear one cycle after the byte that causes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_mode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_byte | input | 8 | Deserializer byte |
| bus_wr | input | 1 | Bus write to the data register |
| bus_wdata | input | 8 | Bus write data |
| bus_rd | input | 1 | Bus read of the data register |
| rd_data | output | 8 | Byte returned by the last read |
| ctl_wr | input | 1 | Control write strobe |
| ctl_rx_rst | input | 1 | Self-clearing receive queue reset command |
| ctl_rx_en | input | 1 | Receiver enable bit value |
| ctl_rx_dis | input | 1 | Receiver disable bit value |
| trig_wr | input | 1 | Threshold write strobe |
| trig_wdata | input | 6 | Threshold value |
| tx_valid | output | 1 | Byte forwarded to the transmitter this cycle |
| tx_byte | output | 8 | Forwarded byte |
| st_empty | output | 1 | Queue empty |
| st_full | output | 1 | Queue full |
| st_trig | output | 1 | Occupancy at or above threshold |
| ovr_pulse | output | 1 | One-cycle overrun indication |

## Verification
A wrong occupancy count shows up within one cycle in the flags. It also shows up at the next read as a zero where a byte was expected, or as a byte where zero was expected. Pointer faults show up at the next drain as bytes out of order or repeated, so every scenario drains the queue and compares each byte with a model list. A routing fault shows up one cycle after the causing strobe, either as a wrong `tx_valid` or as a queue that holds too many or too few bytes at the next drain.

// File: rtl/rxq_pkg.sv
// Shared types for the receive byte queue.
package rxq_pkg;
    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LOCAL  = 2'd2,
        CH_REMOTE = 2'd3
    } chan_mode_e;
endpackage

// File: rtl/rxq_route.sv
// Byte router: decides, from the channel mode, which incoming byte is
// offered to the queue and which is forwarded to the transmitter.
// Assumes at most one source matters per mode; purely combinational.
module rxq_route #(
    parameter int DW = 8
) (
    input  logic [1:0]    mode,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic          push_req,
    output logic [DW-1:0] push_byte,
    output logic          fwd_req,
    output logic [DW-1:0] fwd_byte
);
    import rxq_pkg::*;

    // Mode decode for store and forward paths
    always_comb begin
        push_req  = 1'b0;
        push_byte = rx_byte;
        fwd_req   = 1'b0;
        fwd_byte  = rx_byte;
        unique case (chan_mode_e'(mode))
            CH_NORMAL: begin
                push_req = rx_valid;
                fwd_req  = bus_wr;
                fwd_byte = bus_wdata;
            end
            CH_ECHO: begin
                push_req = rx_valid;
                fwd_req  = rx_valid;
            end
            CH_LOCAL: begin
                push_req  = bus_wr;
                push_byte = bus_wdata;
            end
            CH_REMOTE: begin
                fwd_req = rx_valid;
            end
        endcase
    end
endmodule

// File: rtl/rxq_ctrl.sv
// Receiver control state: enable and disable bits and trigger threshold.
// Assumes control writes are single-cycle strobes; reset command is not stored.
module rxq_ctrl #(
    parameter int              TRIG_W   = 6,
    parameter logic [TRIG_W-1:0] TRIG_RST = 6'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_rx_rst,
    input  logic              ctl_rx_en,
    input  logic              ctl_rx_dis,
    input  logic              trig_wr,
    input  logic [TRIG_W-1:0] trig_wdata,
    output logic              rx_on,
    output logic              flush,
    output logic [TRIG_W-1:0] trig_level
);
    logic en_q;
    logic dis_q;

    // Enable/disable bits, reset to disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            dis_q <= 1'b1;
        end else if (ctl_wr) begin
            en_q  <= ctl_rx_en;
            dis_q <= ctl_rx_dis;
        end
    end

    // Trigger threshold register
    always_ff @(posedge clk) begin
        if (!rst_n)       trig_level <= TRIG_RST;
        else if (trig_wr) trig_level <= trig_wdata;
    end

    assign rx_on = en_q & ~dis_q;
    assign flush = ctl_wr & ctl_rx_rst;
endmodule

// File: rtl/rxq_store.sv
// Circular byte store with occupancy count. Refuses a push when full
// (reported as drop) and a pop when empty. Flush has priority over both.
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          push_acc,
    output logic          pop_acc,
    output logic          drop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] occ
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          is_full;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_full  = (occ == CW'(DEPTH));
    assign push_acc = push & ~is_full;
    assign drop     = push & is_full;
    assign pop_acc  = pop & (occ != '0);
    assign head     = mem[rptr];

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (push_acc) wptr <= ptr_inc(wptr);
            if (pop_acc)  rptr <= ptr_inc(rptr);
            case ({push_acc, pop_acc})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // Data storage write
    always_ff @(posedge clk) begin
        if (push_acc && !flush) mem[wptr] <= push_data;
    end
endmodule

// File: rtl/rx_byte_queue.sv
// Receive byte queue top: routes bytes by channel mode, gates the queue
// with the receiver enable, registers read data, forwarded byte and overrun.
// Assumes one bus access (read or write) per cycle at most.
module rx_byte_queue #(
    parameter int DEPTH  = 16,
    parameter int DW     = 8,
    parameter int TRIG_W = 6,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chan_mode,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_byte,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    output logic [DW-1:0]     rd_data,
    input  logic              ctl_wr,
    input  logic              ctl_rx_rst,
    input  logic              ctl_rx_en,
    input  logic              ctl_rx_dis,
    input  logic              trig_wr,
    input  logic [TRIG_W-1:0] trig_wdata,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_byte,
    output logic              st_empty,
    output logic              st_full,
    output logic              st_trig,
    output logic              ovr_pulse
);
    logic              push_req;
    logic [DW-1:0]     push_byte;
    logic              fwd_req;
    logic [DW-1:0]     fwd_byte;
    logic              rx_on;
    logic              flush;
    logic [TRIG_W-1:0] trig_level;
    logic              push_acc;
    logic              pop_acc;
    logic              drop;
    logic [DW-1:0]     head;
    logic [CW-1:0]     occ;

    rxq_route #(.DW(DW)) u_route (
        .mode      (chan_mode),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .push_req  (push_req),
        .push_byte (push_byte),
        .fwd_req   (fwd_req),
        .fwd_byte  (fwd_byte)
    );

    rxq_ctrl #(.TRIG_W(TRIG_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_rx_rst (ctl_rx_rst),
        .ctl_rx_en  (ctl_rx_en),
        .ctl_rx_dis (ctl_rx_dis),
        .trig_wr    (trig_wr),
        .trig_wdata (trig_wdata),
        .rx_on      (rx_on),
        .flush      (flush),
        .trig_level (trig_level)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push_req & rx_on),
        .push_data (push_byte),
        .pop       (bus_rd & rx_on),
        .push_acc  (push_acc),
        .pop_acc   (pop_acc),
        .drop      (drop),
        .head      (head),
        .occ       (occ)
    );

    // Status flags from the occupancy
    assign st_empty = (occ == '0);
    assign st_full  = (occ == CW'(DEPTH));
    assign st_trig  = (32'(occ) >= 32'(trig_level));

    // Forward path to the transmitter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= fwd_req;
            if (fwd_req) tx_byte <= fwd_byte;
        end
    end

    // Read data: head on an accepted pop, zero on any other read
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (bus_rd) rd_data <= pop_acc ? head : '0;
    end

    // One-cycle overrun indication
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_pulse <= 1'b0;
        else        ovr_pulse <= drop;
    end
endmodule

// File: rtl/rx_byte_queue_chk.sv
// Property checker for the receive byte queue, bound to the top module.
module rx_byte_queue_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    chan_mode,
    input logic          bus_rd,
    input logic          ctl_wr,
    input logic          ctl_rx_rst,
    input logic [DW-1:0] rd_data,
    input logic          tx_valid,
    input logic          ovr_pulse,
    input logic          st_empty,
    input logic          st_full,
    input logic          rx_on,
    input logic          push_acc,
    input logic          pop_acc,
    input logic [CW-1:0] occ
);
    a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occ) <= DEPTH);
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_empty && st_full));
    a_r6_ovr_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> $past(st_full));
    a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && st_empty) |=> (rd_data == '0));
    a_r9_off_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !rx_on) |=> (rd_data == '0));
    a_r9_off_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on |=> (occ <= $past(occ)));
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_rx_rst) |=> (st_empty && !st_full));
    a_r4_local_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'd2) |=> !tx_valid);
    a_r11_pushpop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc && pop_acc && !(ctl_wr && ctl_rx_rst)) |=> $stable(occ));
endmodule

bind rx_byte_queue rx_byte_queue_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_mode  (chan_mode),
    .bus_rd     (bus_rd),
    .ctl_wr     (ctl_wr),
    .ctl_rx_rst (ctl_rx_rst),
    .rd_data    (rd_data),
    .tx_valid   (tx_valid),
    .ovr_pulse  (ovr_pulse),
    .st_empty   (st_empty),
    .st_full    (st_full),
    .rx_on      (rx_on),
    .push_acc   (push_acc),
    .pop_acc    (pop_acc),
    .occ        (occ)
);

// File: tb/rx_byte_queue_bench.sv
module rx_byte_queue_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chan_mode = 2'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] rd_data;
    logic       ctl_wr = 1'b0;
    logic       ctl_rx_rst = 1'b0;
    logic       ctl_rx_en = 1'b0;
    logic       ctl_rx_dis = 1'b0;
    logic       trig_wr = 1'b0;
    logic [5:0] trig_wdata = '0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       st_empty, st_full, st_trig, ovr_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic       cap_txv;
    logic [7:0] cap_txb;
    logic       cap_ovr;
    logic [7:0] cap_rd;

    rx_byte_queue u_rx_byte_queue (
        .clk(clk), .rst_n(rst_n), .chan_mode(chan_mode),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .rd_data(rd_data),
        .ctl_wr(ctl_wr), .ctl_rx_rst(ctl_rx_rst),
        .ctl_rx_en(ctl_rx_en), .ctl_rx_dis(ctl_rx_dis),
        .trig_wr(trig_wr), .trig_wdata(trig_wdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte),
        .st_empty(st_empty), .st_full(st_full), .st_trig(st_trig),
        .ovr_pulse(ovr_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        cap_txv = tx_valid; cap_txb = tx_byte; cap_ovr = ovr_pulse;
        rx_valid = 1'b0;
    endtask

    task automatic write_data(input logic [7:0] b);
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = b;
        @(negedge clk);
        cap_txv = tx_valid; cap_txb = tx_byte; cap_ovr = ovr_pulse;
        bus_wr = 1'b0;
    endtask

    task automatic read_data();
        @(negedge clk);
        bus_rd = 1'b1;
        @(negedge clk);
        cap_rd = rd_data;
        bus_rd = 1'b0;
    endtask

    task automatic ctl_write(input logic rst, input logic en, input logic dis);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_rx_rst = rst; ctl_rx_en = en; ctl_rx_dis = dis;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_rx_rst = 1'b0;
    endtask

    task automatic trig_write(input logic [5:0] v);
        @(negedge clk);
        trig_wr = 1'b1; trig_wdata = v;
        @(negedge clk);
        trig_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 empty after reset", st_empty, 1);
        check("R1 not full after reset", st_full, 0);
        check("R7 trig low after reset", st_trig, 0);
        check("R6 no overrun after reset", ovr_pulse, 0);
        check("R12 tx idle after reset", tx_valid, 0);
    endtask

    task automatic t_disabled();
        chan_mode = 2'd0;
        push_rx(8'h11);
        check("R9 store ignored at reset state", st_empty, 1);
        ctl_write(1'b0, 1'b1, 1'b1);
        push_rx(8'h12);
        check("R9 store ignored with enable and disable set", st_empty, 1);
        ctl_write(1'b0, 1'b1, 1'b0);
        read_data();
        check("R8 empty read zero", cap_rd, 0);
        check("R8 empty stays", st_empty, 1);
    endtask

    task automatic t_normal();
        chan_mode = 2'd0;
        push_rx(8'hA1);
        check("R2 no forward of received byte", cap_txv, 0);
        push_rx(8'hA2);
        push_rx(8'hA3);
        write_data(8'h55);
        check("R2 bus write forwarded", cap_txv, 1);
        check("R12 forwarded byte", cap_txb, 8'h55);
        read_data(); check("R11 order 1", cap_rd, 8'hA1);
        read_data(); check("R11 order 2", cap_rd, 8'hA2);
        read_data(); check("R11 order 3", cap_rd, 8'hA3);
        check("R2 bus write not stored", st_empty, 1);
    endtask

    task automatic t_echo();
        chan_mode = 2'd1;
        push_rx(8'h5A);
        check("R3 echo forwards", cap_txv, 1);
        check("R3 echo forwarded byte", cap_txb, 8'h5A);
        read_data(); check("R3 echo stored", cap_rd, 8'h5A);
        check("R3 echo drained", st_empty, 1);
    endtask

    task automatic t_local();
        chan_mode = 2'd2;
        write_data(8'h66);
        check("R4 local no forward", cap_txv, 0);
        push_rx(8'h77);
        check("R4 local rx not forwarded", cap_txv, 0);
        read_data(); check("R4 local stores bus write", cap_rd, 8'h66);
        check("R4 rx byte ignored", st_empty, 1);
    endtask

    task automatic t_remote();
        chan_mode = 2'd3;
        push_rx(8'h88);
        check("R5 remote forwards", cap_txv, 1);
        check("R5 remote forwarded byte", cap_txb, 8'h88);
        check("R5 remote not stored", st_empty, 1);
    endtask

    task automatic t_fill_overrun();
        chan_mode = 2'd0;
        for (int i = 0; i < 16; i++) begin
            push_rx(8'h20 + 8'(i));
            if (i == 14) check("R1 not full at 15", st_full, 0);
        end
        check("R1 full at 16", st_full, 1);
        check("R7 threshold 32 keeps trig low", st_trig, 0);
        push_rx(8'hEE);
        check("R6 overrun pulse", cap_ovr, 1);
        @(negedge clk);
        check("R6 overrun one cycle", ovr_pulse, 0);
        for (int i = 0; i < 16; i++) begin
            read_data();
            check("R6 contents kept", cap_rd, 8'h20 + 8'(i));
        end
        check("R6 dropped byte absent", st_empty, 1);
    endtask

    task automatic t_trigger();
        chan_mode = 2'd0;
        trig_write(6'd4);
        push_rx(8'h01); push_rx(8'h02); push_rx(8'h03);
        check("R7 below threshold", st_trig, 0);
        push_rx(8'h04);
        check("R7 at threshold", st_trig, 1);
        read_data();
        check("R7 drops below", st_trig, 0);
        trig_write(6'd2);
        check("R7 lower threshold", st_trig, 1);
        ctl_write(1'b1, 1'b1, 1'b0);
        check("R10 flush empties", st_empty, 1);
        check("R10 not full", st_full, 0);
        read_data();
        check("R10 old bytes gone", cap_rd, 0);
    endtask

    task automatic t_push_pop();
        chan_mode = 2'd0;
        push_rx(8'h31); push_rx(8'h32);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h33; bus_rd = 1'b1;
        @(negedge clk);
        cap_rd = rd_data;
        rx_valid = 1'b0; bus_rd = 1'b0;
        check("R11 simultaneous read data", cap_rd, 8'h31);
        read_data(); check("R11 after simultaneous 1", cap_rd, 8'h32);
        read_data(); check("R11 after simultaneous 2", cap_rd, 8'h33);
        check("R11 occupancy held", st_empty, 1);
    endtask

    task automatic t_disable_hold();
        chan_mode = 2'd0;
        push_rx(8'h44);
        ctl_write(1'b0, 1'b1, 1'b1);
        read_data();
        check("R9 disabled read zero", cap_rd, 0);
        check("R9 disabled read no pop", st_empty, 0);
        ctl_write(1'b0, 1'b1, 1'b0);
        read_data();
        check("R9 byte kept while disabled", cap_rd, 8'h44);
        check("R12 rd_data holds", rd_data, 8'h44);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= WATCHDOG) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_disabled();
        t_normal();
        t_echo();
        t_local();
        t_remote();
        t_fill_overrun();
        t_trigger();
        t_push_pop();
        t_disable_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule